// File: doc/BRIEF.md
# Ring Buffer Delay Controller

This block steers a circular store of fixed-size audio blocks held in external memory. It keeps a write block index that advances once per arriving block. It also keeps a read block index that trails the write index by a gap. The gap is worked out from the delay the user has asked for and from the measured spacing between block arrivals. That spacing is counted in cycles of a fixed reference clock. When the incoming rate changes, the gap follows on its own, so a fixed delay in time holds whatever the stream's block rate.

The delay is held in 10 ms units. Decoded remote-control key codes change it: digits pick a value directly, two key pairs step it coarsely or finely, and the value is always clamped to the legal range. A further key toggles a bypass mode. In bypass the read index trails the write index by one block, which gives minimal latency. A buffering flag stays high until enough blocks have been written to cover the current gap. It starts high again after reset and after every change of the delay.

Top module: `ring_delay_ctrl`

## Requirements
- R1: After reset, wr_idx_o and rd_idx_o are 0, delay_o equals DLY_RST (20, i.e. 200 ms), bypass_o is 0 and buffering_o is 1.
- R2: Each clock with blk_stb_i high advances wr_idx_o by one, wrapping from RING_BLKS-1 to 0. Without a strobe it holds.
- R3: The block period is the number of clock cycles from one strobe to the next. The first strobe after reset only starts the count. Until a period has been measured, the gap is 1.
- R4: The gap is (delay_o*TICKS_PER_STEP + floor(period/2)) / period, rounded down after that half-period bias. It is raised to 1 if it would be 0 and limited to RING_BLKS-1.
- R5: On each strobe, rd_idx_o becomes (new wr_idx_o - gap) modulo RING_BLKS, using the gap in force in the strobe cycle. Otherwise it holds.
- R6: A valid key code d in 1..9 sets delay_o to 10*d. Code 0 sets it to 100. Both values are clamped to [DLY_MIN, DLY_MAX] = [2, 150].
- R7: Code 10 adds 10 to delay_o and code 11 subtracts 10, with the result clamped to [2, 150].
- R8: Code 12 adds 1 to delay_o and code 13 subtracts 1, with the result clamped to [2, 150].
- R9: Code 14 toggles bypass_o. While bypass_o is 1, the gap is 1.
- R10: Codes 15..63, and any code presented with key_vld_i low, leave delay_o and bypass_o unchanged.
- R11: buffering_o is 1 while the number of strobes since reset, or since the last change of delay_o, is below the gap. A key that changes delay_o in the same cycle as a strobe leaves that count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| blk_stb_i | input | 1 | One-cycle pulse per completed input block |
| key_vld_i | input | 1 | Key code valid |
| key_code_i | input | 6 | Decoded remote key code |
| wr_idx_o | output | $clog2(RING_BLKS) | Block index being written |
| rd_idx_o | output | $clog2(RING_BLKS) | Block index being read |
| bypass_o | output | 1 | Bypass (minimum delay) active |
| delay_o | output | DLY_W | Delay setting in 10 ms units |
| buffering_o | output | 1 | Ring not yet filled to the current gap |

## Verification
The bench drives a short ring so that wrap-around of both indices is reached quickly. A design with a wrong modulo would read from a block beyond the ring or jump the read index backwards. Delays are chosen so the gap falls exactly on a half-block rounding point, on the floor of 1 and on the ring ceiling. A design that truncated instead of rounding, or that failed to clamp, would show the wrong spacing between the indices. Key steps are pushed past both ends of the delay range, and undefined codes are sent, to catch missing saturation or stray decodes. The block period is switched mid-run, and a delay change is placed on a strobe cycle, to expose a gap that does not track the rate or a fill count that misses its clear.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
  localparam int KEY_W = 6;
  localparam logic [KEY_W-1:0] KEY_CH_UP  = 6'd10;
  localparam logic [KEY_W-1:0] KEY_CH_DN  = 6'd11;
  localparam logic [KEY_W-1:0] KEY_VOL_UP = 6'd12;
  localparam logic [KEY_W-1:0] KEY_VOL_DN = 6'd13;
  localparam logic [KEY_W-1:0] KEY_MUTE   = 6'd14;

  function automatic int clamp_i(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction
endpackage

// File: rtl/rdc_keys.sv
module rdc_keys import rdc_pkg::*; #(
  parameter int DLY_W   = 8,
  parameter int DLY_MIN = 2,
  parameter int DLY_MAX = 150,
  parameter int DLY_RST = 20,
  parameter int STEP_C  = 10,
  parameter int STEP_D  = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             key_vld_i,
  input  logic [KEY_W-1:0] key_code_i,
  output logic [DLY_W-1:0] dly_o,
  output logic             byp_o,
  output logic             dly_chg_o
);
  logic [DLY_W-1:0] dly_q, dly_n;
  logic             byp_q, tgl;

  always_comb begin
    int t;
    t = int'(dly_q);
    tgl = 1'b0;
    if (key_vld_i) begin
      if (key_code_i == 6'd0)          t = 10 * STEP_D;
      else if (key_code_i <= 6'd9)     t = int'(key_code_i) * STEP_D;
      else if (key_code_i == KEY_CH_UP)  t = t + STEP_C;
      else if (key_code_i == KEY_CH_DN)  t = t - STEP_C;
      else if (key_code_i == KEY_VOL_UP) t = t + 1;
      else if (key_code_i == KEY_VOL_DN) t = t - 1;
      else if (key_code_i == KEY_MUTE)   tgl = 1'b1;
    end
    dly_n = DLY_W'(clamp_i(t, DLY_MIN, DLY_MAX));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q <= DLY_W'(DLY_RST);
      byp_q <= 1'b0;
    end else begin
      dly_q <= dly_n;
      if (tgl) byp_q <= ~byp_q;
    end
  end

  assign dly_o     = dly_q;
  assign byp_o     = byp_q;
  assign dly_chg_o = key_vld_i && (dly_n != dly_q);

  // R7
  dly_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(dly_q) >= DLY_MIN) && (int'(dly_q) <= DLY_MAX));
  // R10
  no_key_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !key_vld_i |=> $stable(dly_q) && $stable(byp_q));
  // R9
  mute_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_vld_i && key_code_i == KEY_MUTE) |=> byp_q != $past(byp_q));
endmodule

// File: rtl/rdc_rate.sv
module rdc_rate #(
  parameter int RING_BLKS      = 4680,
  parameter int TICKS_PER_STEP = 400000,
  parameter int PER_W          = 24,
  parameter int DLY_W          = 8,
  localparam int IDX_W = $clog2(RING_BLKS),
  localparam int NUM_W = DLY_W + $clog2(TICKS_PER_STEP + 1),
  localparam int CW    = NUM_W + PER_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stb_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic [IDX_W-1:0] gap_o
);
  localparam logic [PER_W-1:0] PER_MAX = '1;

  logic [PER_W-1:0] cnt_q, per_q;
  logic             seen_q;
  logic [CW-1:0]    num, div, quo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      per_q  <= '0;
      seen_q <= 1'b0;
    end else if (stb_i) begin
      if (seen_q) per_q <= (cnt_q == PER_MAX) ? PER_MAX : cnt_q + 1'b1;
      cnt_q  <= '0;
      seen_q <= 1'b1;
    end else if (cnt_q != PER_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    num = CW'(dly_i) * CW'(TICKS_PER_STEP);
    div = (per_q == '0) ? CW'(1) : CW'(per_q);
    quo = (num + (div >> 1)) / div;
    if (per_q == '0 || quo == '0)      gap_o = IDX_W'(1);
    else if (quo > CW'(RING_BLKS - 1)) gap_o = IDX_W'(RING_BLKS - 1);
    else                               gap_o = IDX_W'(quo);
  end

  // R4
  gap_bounds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gap_o >= IDX_W'(1)) && (int'(gap_o) <= RING_BLKS - 1));
  // R3
  no_period_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> gap_o == IDX_W'(1));
endmodule

// File: rtl/rdc_ring.sv
module rdc_ring #(
  parameter int RING_BLKS = 4680,
  localparam int IDX_W = $clog2(RING_BLKS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stb_i,
  input  logic             clr_i,
  input  logic [IDX_W-1:0] gap_i,
  output logic [IDX_W-1:0] wr_o,
  output logic [IDX_W-1:0] rd_o,
  output logic             buf_o
);
  logic [IDX_W-1:0] wr_q, rd_q, wr_n;
  logic [IDX_W:0]   fill_q, wn_x, g_x, rd_x;

  always_comb begin
    wr_n = (int'(wr_q) == RING_BLKS - 1) ? '0 : wr_q + 1'b1;
    wn_x = {1'b0, wr_n};
    g_x  = {1'b0, gap_i};
    rd_x = (wn_x >= g_x) ? wn_x - g_x : wn_x + (IDX_W+1)'(RING_BLKS) - g_x;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= '0;
      rd_q   <= '0;
      fill_q <= '0;
    end else begin
      if (stb_i) begin
        wr_q <= wr_n;
        rd_q <= IDX_W'(rd_x);
      end
      if (clr_i) fill_q <= '0;
      else if (stb_i && int'(fill_q) < RING_BLKS) fill_q <= fill_q + 1'b1;
    end
  end

  assign wr_o  = wr_q;
  assign rd_o  = rd_q;
  assign buf_o = fill_q < g_x;

  // R2
  wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_i |=> $stable(wr_q) && $stable(rd_q));
  // R5
  rd_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(rd_q) < RING_BLKS);
  // R11
  clr_buf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> buf_o);
endmodule

// File: rtl/ring_delay_ctrl.sv
module ring_delay_ctrl import rdc_pkg::*; #(
  parameter int RING_BLKS      = 4680,
  parameter int TICKS_PER_STEP = 400000,
  parameter int PER_W          = 24,
  parameter int DLY_W          = 8,
  parameter int DLY_MIN        = 2,
  parameter int DLY_MAX        = 150,
  parameter int DLY_RST        = 20
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         blk_stb_i,
  input  logic                         key_vld_i,
  input  logic [5:0]                   key_code_i,
  output logic [$clog2(RING_BLKS)-1:0] wr_idx_o,
  output logic [$clog2(RING_BLKS)-1:0] rd_idx_o,
  output logic                         bypass_o,
  output logic [DLY_W-1:0]             delay_o,
  output logic                         buffering_o
);
  localparam int IDX_W = $clog2(RING_BLKS);

  logic [DLY_W-1:0] dly;
  logic             byp, chg;
  logic [IDX_W-1:0] gap_calc, gap_eff;

  rdc_keys #(
    .DLY_W(DLY_W), .DLY_MIN(DLY_MIN), .DLY_MAX(DLY_MAX), .DLY_RST(DLY_RST),
    .STEP_C(10), .STEP_D(10)
  ) u_keys (
    .clk_i(clk_i), .rst_ni(rst_ni), .key_vld_i(key_vld_i), .key_code_i(key_code_i),
    .dly_o(dly), .byp_o(byp), .dly_chg_o(chg)
  );

  rdc_rate #(
    .RING_BLKS(RING_BLKS), .TICKS_PER_STEP(TICKS_PER_STEP), .PER_W(PER_W), .DLY_W(DLY_W)
  ) u_rate (
    .clk_i(clk_i), .rst_ni(rst_ni), .stb_i(blk_stb_i), .dly_i(dly), .gap_o(gap_calc)
  );

  assign gap_eff = byp ? IDX_W'(1) : gap_calc;

  rdc_ring #(.RING_BLKS(RING_BLKS)) u_ring (
    .clk_i(clk_i), .rst_ni(rst_ni), .stb_i(blk_stb_i), .clr_i(chg), .gap_i(gap_eff),
    .wr_o(wr_idx_o), .rd_o(rd_idx_o), .buf_o(buffering_o)
  );

  assign bypass_o = byp;
  assign delay_o  = dly;

  // R9
  byp_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byp && blk_stb_i) |=> (rd_idx_o == (wr_idx_o == '0 ? IDX_W'(RING_BLKS - 1) : wr_idx_o - 1'b1)));
endmodule

// File: tb/tb_ring_delay_ctrl.sv
module tb_ring_delay_ctrl;
  localparam int RING  = 40;
  localparam int TICKS = 5;
  localparam int PW    = 12;
  localparam int PMAX  = (1 << PW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, stb = 1'b0, kv = 1'b0;
  logic [5:0] kc = '0;
  logic [5:0] wr, rd;
  logic       byp, bufo;
  logic [7:0] dly;

  int total = 0, bad = 0;
  bit live = 0, done = 0;

  int m_wr = 0, m_rd = 0, m_dly = 20, m_fill = 0, m_cnt = 0, m_per = 0;
  bit m_byp = 0, m_seen = 0;

  always #10 clk = ~clk;

  ring_delay_ctrl #(.RING_BLKS(RING), .TICKS_PER_STEP(TICKS), .PER_W(PW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .blk_stb_i(stb), .key_vld_i(kv), .key_code_i(kc),
    .wr_idx_o(wr), .rd_idx_o(rd), .bypass_o(byp), .delay_o(dly), .buffering_o(bufo)
  );

  function automatic int clampv(int v);
    return v < 2 ? 2 : (v > 150 ? 150 : v);
  endfunction

  function automatic int mgap(int d, int p, bit b);
    int q;
    if (b || p == 0) return 1;
    q = (d * TICKS + p / 2) / p;
    if (q < 1) q = 1;
    if (q > RING - 1) q = RING - 1;
    return q;
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      int g, nd, nwr;
      bit chg;
      g = mgap(m_dly, m_per, m_byp);
      nd = m_dly;
      if (kv) begin
        if (kc == 0) nd = clampv(100);
        else if (kc <= 9) nd = clampv(kc * 10);
        else if (kc == 10) nd = clampv(m_dly + 10);
        else if (kc == 11) nd = clampv(m_dly - 10);
        else if (kc == 12) nd = clampv(m_dly + 1);
        else if (kc == 13) nd = clampv(m_dly - 1);
        else if (kc == 14) m_byp = !m_byp;
      end
      chg = kv && (nd != m_dly);
      if (stb) begin
        nwr = (m_wr + 1) % RING;
        m_wr = nwr;
        m_rd = (nwr - g + RING) % RING;
      end
      if (chg) m_fill = 0;
      else if (stb && m_fill < RING) m_fill++;
      if (stb) begin
        if (m_seen) m_per = (m_cnt == PMAX) ? PMAX : m_cnt + 1;
        m_cnt = 0;
        m_seen = 1;
      end else if (m_cnt != PMAX) m_cnt++;
      m_dly = nd;
    end
  end

  always @(negedge clk) begin
    if (live && rst_n) begin
      check("R2 wr", int'(wr), m_wr);
      check("R5 rd", int'(rd), m_rd);
      check("R6 delay", int'(dly), m_dly);
      check("R9 bypass", int'(byp), int'(m_byp));
      check("R11 buffering", int'(bufo), int'(m_fill < mgap(m_dly, m_per, m_byp)));
    end
  end

  int phase = 0;
  task automatic run(int n, int per);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      kv = 1'b0;
      stb = (phase % per) == per - 1;
      phase++;
    end
    @(negedge clk);
    stb = 1'b0;
  endtask

  task automatic key(int code);
    @(negedge clk);
    stb = 1'b0; kv = 1'b1; kc = 6'(code);
    @(negedge clk);
    kv = 1'b0;
  endtask

  function automatic int spacing();
    return (int'(wr) - int'(rd) + RING) % RING;
  endfunction

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check("R1 wr", int'(wr), 0);
    check("R1 rd", int'(rd), 0);
    check("R1 delay", int'(dly), 20);
    check("R1 bypass", int'(byp), 0);
    check("R1 buffering", int'(bufo), 1);
    rst_n = 1'b1;
    live = 1;
    // R3 before a period exists gap is 1
    @(negedge clk); stb = 1'b1; @(negedge clk); stb = 1'b0;
    check("R3 first strobe gap", spacing(), 1);
    // R2 R4: period 10, delay 20 -> gap 10; wraps ring
    run(500, 10);
    check("R4 gap d20 p10", spacing(), 10);
    check("R11 filled", int'(bufo), 0);
    // R6 digits
    for (int d = 1; d <= 9; d++) begin
      key(d);
      check("R6 digit", int'(dly), d * 10);
    end
    key(0);
    check("R6 digit0", int'(dly), 100);
    // R7 coarse clamp high
    for (int i = 0; i < 7; i++) key(10);
    check("R7 up clamp", int'(dly), 150);
    run(60, 10);
    check("R4 ceiling", spacing(), RING - 1);
    key(1);
    key(11);
    check("R7 down", int'(dly), 2);
    // R8 fine
    key(12); key(12);
    check("R8 up", int'(dly), 4);
    for (int i = 0; i < 5; i++) key(13);
    check("R8 down clamp", int'(dly), 2);
    // R10 undefined codes and invalid flag
    key(15); key(63);
    @(negedge clk); kv = 1'b0; kc = 6'd10; @(negedge clk);
    check("R10 delay", int'(dly), 2);
    check("R10 bypass", int'(byp), 0);
    // R4 rounding: delay 3 period 10 -> 1.5 -> 2
    key(12);
    run(40, 10);
    check("R4 round half", spacing(), 2);
    // R3 period change: delay 2 period 25 -> 0.4 -> floor 1
    key(13);
    run(100, 25);
    check("R4 floor", spacing(), 1);
    key(3);
    run(100, 7);
    check("R3 rate change", spacing(), 21);
    // R9 bypass
    key(14);
    check("R9 on", int'(byp), 1);
    run(30, 7);
    check("R9 gap", spacing(), 1);
    key(14);
    check("R9 off", int'(byp), 0);
    run(200, 7);
    check("R9 restored", spacing(), 21);
    // R11 key on strobe cycle
    @(negedge clk); stb = 1'b1; kv = 1'b1; kc = 6'd5;
    @(negedge clk); stb = 1'b0; kv = 1'b0;
    check("R11 clear on strobe", int'(bufo), 1);
    run(300, 7);
    check("R11 refilled", int'(bufo), 0);
    finish_up();
  end
endmodule